// File: doc/BRIEF.md
# Post-VCO Clock Divider Tree

This block turns one fast source tick stream into two rate-enable pulse trains: a byte-rate enable and a pixel-rate enable. The source is modelled as one-cycle tick pulses on a single fast clock, either the internal tick input or the external tick input, picked by a source-select bit. All derived rates are single-cycle enables on that same clock. No derived clock nets are made.

A power-of-two first stage feeds a one-based bit-rate divider. A fixed divide-by-8 of the bit rate gives the byte enable. Fixed halving of the bit rate and quartering of the first-stage output give two more taps. A four-way tap selector, followed by a one-based pixel divider, gives the pixel enable. Divide ratios and selections come from packed fields in two 8-bit configuration registers and a 2-bit power-of-two register. A global enable bit gates both outputs.

Each stage loads a new ratio only when its counter is at the start of a period. The pixel tap selector switches only when the pixel divider is at the start of a period. A period already in progress therefore always completes with its old setting.

Top module: `vco_post_div`

## Requirements
- R1: After reset all three configuration registers are zero, and both `byte_en_o` and `pix_en_o` are low. They stay low until the global enable is written.
- R2: The first stage divides the source tick rate by 2^N, where N is the 2-bit value written through `odiv_wdata_i`.
- R3: The bit-rate divider ratio B is `cfg0[3:0]`, one-based. The byte enable pulses once every 2^N·B·8 source ticks.
- R4: `cfg1[1:0]` selects the pixel tap: 0 is the bit rate, 1 is the bit rate /2, 2 is the first-stage output, and 3 is the first-stage output /4.
- R5: The pixel divider ratio P is `cfg0[7:4]`, one-based. The pixel enable pulses once every P selected-tap pulses.
- R6: A one-based field value of 0 holds that stage silent. B=0 silences the byte enable and taps 0 and 1, but leaves taps 2 and 3 running. P=0 silences the pixel enable.
- R7: `cfg1[5]` is the global enable. From the cycle after it is written 0, both outputs stay low.
- R8: `cfg1[2]` selects the source. A value of 1 takes ticks from `ext_tick_i` and ignores `int_tick_i`. A value of 0 takes ticks from `int_tick_i`.
- R9: A new ratio or tap selection takes effect only when the affected stage's counter is at the start of a period. The period in progress finishes with the old setting.
- R10: Each output enable is high for exactly one clock per output period. The byte enable is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| int_tick_i | input | 1 | Internal source tick |
| ext_tick_i | input | 1 | External source tick |
| cfg0_we_i | input | 1 | Write strobe, config register 0 |
| cfg0_wdata_i | input | 8 | Config 0 data: [7:4] pixel ratio, [3:0] bit ratio |
| cfg1_we_i | input | 1 | Write strobe, config register 1 |
| cfg1_wdata_i | input | 8 | Config 1 data: [5] enable, [2] source select, [1:0] tap |
| odiv_we_i | input | 1 | Write strobe, power-of-two register |
| odiv_wdata_i | input | 2 | First-stage exponent N |
| byte_en_o | output | 1 | Byte-rate enable pulse |
| pix_en_o | output | 1 | Pixel-rate enable pulse |

## Verification
A register write lands on the clock edge that samples its strobe. Each stage picks up the new value on a later edge where its counter is zero. Both outputs are registered, so a source tick that completes an output period shows up one cycle after the edge that consumed it.

The bench avoids absolute latency in most checks. It lets each configuration settle for longer than any old period, then measures the cycle count between two consecutive output pulses. The deferred-change check is the exception. It writes a new bit ratio on the cycle after a byte pulse, and expects the next byte pulse exactly 18 cycles later: one old bit period of 4 plus seven new bit periods of 2. Gating is checked over a window that starts one cycle after the disabling write.

// File: rtl/div_tree_pkg.sv
package div_tree_pkg;
  localparam int CFG_W    = 8;
  localparam int FIELD_W  = 4;
  localparam int BIT_LSB  = 0;
  localparam int PIX_LSB  = 4;
  localparam int TAP_LSB  = 0;
  localparam int TAP_W    = 2;
  localparam int SRC_BIT  = 2;
  localparam int EN_BIT   = 5;
  localparam int NSTAGE   = 6;

  typedef enum logic [TAP_W-1:0] {
    TAP_BIT       = 2'd0,
    TAP_BIT_HALF  = 2'd1,
    TAP_FIRST     = 2'd2,
    TAP_FIRST_QTR = 2'd3
  } tap_e;

  // stage indices
  localparam int ST_FIRST = 0;
  localparam int ST_BIT   = 1;
  localparam int ST_BYTE  = 2;
  localparam int ST_HALF  = 3;
  localparam int ST_QTR   = 4;
  localparam int ST_PIX   = 5;
endpackage

// File: rtl/div_cfg_regs.sv
module div_cfg_regs #(
  parameter int CFG_W  = 8,
  parameter int ODIV_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg0_we_i,
  input  logic [CFG_W-1:0]  cfg0_wdata_i,
  input  logic              cfg1_we_i,
  input  logic [CFG_W-1:0]  cfg1_wdata_i,
  input  logic              odiv_we_i,
  input  logic [ODIV_W-1:0] odiv_wdata_i,
  output logic [CFG_W-1:0]  cfg0_o,
  output logic [CFG_W-1:0]  cfg1_o,
  output logic [ODIV_W-1:0] odiv_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg0_o <= '0;
      cfg1_o <= '0;
      odiv_o <= '0;
    end else begin
      if (cfg0_we_i) cfg0_o <= cfg0_wdata_i;
      if (cfg1_we_i) cfg1_o <= cfg1_wdata_i;
      if (odiv_we_i) odiv_o <= odiv_wdata_i;
    end
  end
endmodule

// File: rtl/tick_div.sv
// One-based tick divider: ratio 0 = silent; ratio loads only while counter is zero.
module tick_div #(
  parameter int RW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [RW-1:0] ratio_i,
  input  logic          tick_i,
  output logic          tick_o,
  output logic          idle_o,
  output logic [RW-1:0] act_o
);
  logic [RW-1:0] cnt_q, act_q;
  logic          last;

  assign last   = (act_q != '0) && (cnt_q == act_q - 1'b1);
  assign tick_o = tick_i && last;
  assign idle_o = (cnt_q == '0);
  assign act_o  = act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= '0;
    end else begin
      if (cnt_q == '0) act_q <= ratio_i;
      if (tick_i && act_q != '0) cnt_q <= last ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tap_select.sv
module tap_select #(
  parameter int SW = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SW-1:0]     sel_i,
  input  logic              upd_i,
  input  logic [(1<<SW)-1:0] taps_i,
  output logic              tick_o,
  output logic [SW-1:0]     sel_o
);
  logic [SW-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sel_q <= '0;
    else if (upd_i) sel_q <= sel_i;
  end

  assign tick_o = taps_i[sel_q];
  assign sel_o  = sel_q;
endmodule

// File: rtl/vco_post_div.sv
module vco_post_div
  import div_tree_pkg::*;
#(
  parameter int DIV_W     = 4,
  parameter int ODIV_W    = 2,
  parameter int BYTE_DIV  = 8,
  parameter int HALF_DIV  = 2,
  parameter int QTR_DIV   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              int_tick_i,
  input  logic              ext_tick_i,
  input  logic              cfg0_we_i,
  input  logic [CFG_W-1:0]  cfg0_wdata_i,
  input  logic              cfg1_we_i,
  input  logic [CFG_W-1:0]  cfg1_wdata_i,
  input  logic              odiv_we_i,
  input  logic [ODIV_W-1:0] odiv_wdata_i,
  output logic              byte_en_o,
  output logic              pix_en_o
);
  localparam logic [DIV_W-1:0] BYTE_R = DIV_W'(BYTE_DIV);
  localparam logic [DIV_W-1:0] HALF_R = DIV_W'(HALF_DIV);
  localparam logic [DIV_W-1:0] QTR_R  = DIV_W'(QTR_DIV);
  localparam logic [DIV_W-1:0] ONE_R  = DIV_W'(1);

  logic [CFG_W-1:0]  cfg0_q, cfg1_q;
  logic [ODIV_W-1:0] odiv_q;
  logic              src_tick, gclk_en;
  logic [DIV_W-1:0]  first_ratio;
  logic              t_first, t_bit, t_byte, t_half, t_qtr, t_tap, t_pix;
  logic [TAP_W-1:0]  tap_q;
  logic [DIV_W-1:0]  stage_act  [NSTAGE];
  logic              stage_idle [NSTAGE];
  logic              unused_cfg;

  div_cfg_regs #(.CFG_W(CFG_W), .ODIV_W(ODIV_W)) u_regs (
    .clk_i, .rst_ni,
    .cfg0_we_i, .cfg0_wdata_i, .cfg1_we_i, .cfg1_wdata_i,
    .odiv_we_i, .odiv_wdata_i,
    .cfg0_o(cfg0_q), .cfg1_o(cfg1_q), .odiv_o(odiv_q)
  );

  assign unused_cfg  = ^{cfg1_q[7:6], cfg1_q[4:3]};
  assign gclk_en     = cfg1_q[EN_BIT];
  assign src_tick    = cfg1_q[SRC_BIT] ? ext_tick_i : int_tick_i;
  assign first_ratio = ONE_R << odiv_q;

  tick_div #(.RW(DIV_W)) u_first (
    .clk_i, .rst_ni, .ratio_i(first_ratio), .tick_i(src_tick), .tick_o(t_first),
    .idle_o(stage_idle[ST_FIRST]), .act_o(stage_act[ST_FIRST]));

  tick_div #(.RW(DIV_W)) u_bit (
    .clk_i, .rst_ni, .ratio_i(cfg0_q[BIT_LSB +: FIELD_W]), .tick_i(t_first),
    .tick_o(t_bit), .idle_o(stage_idle[ST_BIT]), .act_o(stage_act[ST_BIT]));

  tick_div #(.RW(DIV_W)) u_byte (
    .clk_i, .rst_ni, .ratio_i(BYTE_R), .tick_i(t_bit), .tick_o(t_byte),
    .idle_o(stage_idle[ST_BYTE]), .act_o(stage_act[ST_BYTE]));

  tick_div #(.RW(DIV_W)) u_half (
    .clk_i, .rst_ni, .ratio_i(HALF_R), .tick_i(t_bit), .tick_o(t_half),
    .idle_o(stage_idle[ST_HALF]), .act_o(stage_act[ST_HALF]));

  tick_div #(.RW(DIV_W)) u_qtr (
    .clk_i, .rst_ni, .ratio_i(QTR_R), .tick_i(t_first), .tick_o(t_qtr),
    .idle_o(stage_idle[ST_QTR]), .act_o(stage_act[ST_QTR]));

  // tap order follows tap_e encoding
  tap_select #(.SW(TAP_W)) u_tap (
    .clk_i, .rst_ni, .sel_i(cfg1_q[TAP_LSB +: TAP_W]), .upd_i(stage_idle[ST_PIX]),
    .taps_i({t_qtr, t_first, t_half, t_bit}), .tick_o(t_tap), .sel_o(tap_q));

  tick_div #(.RW(DIV_W)) u_pix (
    .clk_i, .rst_ni, .ratio_i(cfg0_q[PIX_LSB +: FIELD_W]), .tick_i(t_tap),
    .tick_o(t_pix), .idle_o(stage_idle[ST_PIX]), .act_o(stage_act[ST_PIX]));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_en_o <= 1'b0;
      pix_en_o  <= 1'b0;
    end else begin
      byte_en_o <= gclk_en && t_byte;
      pix_en_o  <= gclk_en && t_pix;
    end
  end
endmodule

// File: rtl/div_tree_checker.sv
module div_tree_checker
  import div_tree_pkg::*;
#(
  parameter int DIV_W = 4,
  parameter int TAP_W_P = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_i,
  input logic               byte_en_i,
  input logic               pix_en_i,
  input logic [TAP_W_P-1:0] sel_i,
  input logic [DIV_W-1:0]   act_i  [NSTAGE],
  input logic               idle_i [NSTAGE]
);
  assert_gate_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> (!byte_en_i && !pix_en_i));

  assert_byte_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_en_i |=> !byte_en_i);

  assert_bit_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i[ST_BIT] == '0) |=> !byte_en_i);

  assert_pix_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i[ST_PIX] == '0) |=> !pix_en_i);

  assert_tap_boundary_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sel_i) |-> $past(idle_i[ST_PIX]));

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    assert_ratio_boundary_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(act_i[g]) |-> $past(idle_i[g]));
  end
endmodule

bind vco_post_div div_tree_checker #(.DIV_W(DIV_W), .TAP_W_P(div_tree_pkg::TAP_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (gclk_en),
  .byte_en_i (byte_en_o),
  .pix_en_i  (pix_en_o),
  .sel_i     (tap_q),
  .act_i     (stage_act),
  .idle_i    (stage_idle)
);

// File: tb/test_vco_post_div.sv
module test_vco_post_div;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       int_tick_i = 1'b1;
  logic       ext_tick_i = 1'b0;
  logic       cfg0_we_i = 1'b0, cfg1_we_i = 1'b0, odiv_we_i = 1'b0;
  logic [7:0] cfg0_wdata_i = '0, cfg1_wdata_i = '0;
  logic [1:0] odiv_wdata_i = '0;
  logic       byte_en_o, pix_en_o;

  int checks = 0;
  int errors = 0;
  int ecnt = 0;

  always #10 clk_i = ~clk_i;

  vco_post_div i_vco_post_div (
    .clk_i, .rst_ni, .int_tick_i, .ext_tick_i,
    .cfg0_we_i, .cfg0_wdata_i, .cfg1_we_i, .cfg1_wdata_i,
    .odiv_we_i, .odiv_wdata_i, .byte_en_o, .pix_en_o
  );

  // external source: one tick every third cycle
  initial forever begin
    @(negedge clk_i);
    ext_tick_i <= (ecnt == 0);
    ecnt = (ecnt == 2) ? 0 : ecnt + 1;
  end

  function automatic bit sig(input bit p);
    return p ? pix_en_o : byte_en_o;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int n, input int b, input int p, input int tap,
                         input int src, input int en);
    cfg0_wdata_i = 8'((p << 4) | b);
    cfg1_wdata_i = 8'((en << 5) | (src << 2) | tap);
    odiv_wdata_i = 2'(n);
    cfg0_we_i = 1'b1; cfg1_we_i = 1'b1; odiv_we_i = 1'b1;
    @(negedge clk_i);
    cfg0_we_i = 1'b0; cfg1_we_i = 1'b0; odiv_we_i = 1'b0;
  endtask

  task automatic meas(input bit p, input int lim, output int d);
    int t;
    d = -1;
    t = 0;
    while (!sig(p) && t < lim) begin @(negedge clk_i); t++; end
    if (sig(p)) begin
      t = 0;
      do begin @(negedge clk_i); t++; end while (!sig(p) && t < lim);
      if (sig(p)) d = t;
    end
  endtask

  task automatic count_win(input bit p, input int w, output int c);
    c = 0;
    for (int i = 0; i < w; i++) begin @(negedge clk_i); if (sig(p)) c++; end
  endtask

  initial begin
    repeat (2000000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int d, c, f, bexp, tapp, pexp;
    repeat (3) @(negedge clk_i);
    chk("R1 reset byte", int'(byte_en_o), 0);
    chk("R1 reset pix", int'(pix_en_o), 0);
    rst_ni = 1'b1;
    count_win(0, 60, c); chk("R1 idle byte", c, 0);
    count_win(1, 60, c); chk("R1 idle pix", c, 0);

    // sweep N, B, tap, P on the internal source
    for (int n = 0; n < 4; n++)
      for (int b = 1; b <= 3; b += 2)
        for (int tap = 0; tap < 4; tap++)
          for (int p = 1; p <= 2; p++) begin
            set_cfg(n, b, p, tap, 0, 1);
            repeat (600) @(negedge clk_i);
            f = 1 << n;
            bexp = f * b * 8;
            case (tap)
              0: tapp = f * b;
              1: tapp = f * b * 2;
              2: tapp = f;
              default: tapp = f * 4;
            endcase
            pexp = tapp * p;
            meas(0, 2 * bexp + 8, d); chk("R2 R3 R10 byte period", d, bexp);
            meas(1, 2 * pexp + 8, d); chk("R4 R5 R10 pix period", d, pexp);
          end

    // zero bit ratio: byte and bit taps silent, first-stage tap alive
    set_cfg(1, 0, 1, 0, 0, 1);
    repeat (100) @(negedge clk_i);
    count_win(0, 400, c); chk("R6 byte with B=0", c, 0);
    count_win(1, 400, c); chk("R6 pix tap0 with B=0", c, 0);
    set_cfg(1, 0, 1, 2, 0, 1);
    repeat (100) @(negedge clk_i);
    meas(1, 40, d); chk("R6 pix tap2 with B=0", d, 2);

    // zero pixel ratio
    set_cfg(0, 1, 0, 2, 0, 1);
    repeat (100) @(negedge clk_i);
    count_win(1, 300, c); chk("R6 pix with P=0", c, 0);
    meas(0, 40, d); chk("R6 byte with P=0", d, 8);

    // global enable
    set_cfg(0, 1, 1, 2, 0, 1);
    repeat (100) @(negedge clk_i);
    set_cfg(0, 1, 1, 2, 0, 0);
    count_win(0, 300, c); chk("R7 byte gated", c, 0);
    count_win(1, 300, c); chk("R7 pix gated", c, 0);
    set_cfg(0, 1, 1, 2, 0, 1);
    meas(1, 20, d); chk("R7 pix regated", d, 1);

    // external source
    set_cfg(0, 1, 1, 2, 1, 1);
    repeat (600) @(negedge clk_i);
    meas(0, 80, d); chk("R8 byte on ext", d, 24);
    meas(1, 20, d); chk("R8 pix on ext", d, 3);
    int_tick_i = 1'b0;
    set_cfg(0, 1, 1, 2, 0, 1);
    repeat (100) @(negedge clk_i);
    count_win(0, 200, c); chk("R8 ext ignored", c, 0);
    int_tick_i = 1'b1;

    // deferred ratio change: old bit period 4 finishes, then seven of 2
    set_cfg(0, 4, 1, 0, 0, 1);
    repeat (600) @(negedge clk_i);
    c = 0;
    while (!byte_en_o && c < 100) begin @(negedge clk_i); c++; end
    cfg0_wdata_i = 8'h12;
    cfg0_we_i = 1'b1;
    @(negedge clk_i);
    cfg0_we_i = 1'b0;
    d = 1;
    while (!byte_en_o && d < 100) begin @(negedge clk_i); d++; end
    chk("R9 deferred byte interval", d, 18);
    meas(0, 60, d); chk("R9 R3 new byte period", d, 16);
    @(negedge clk_i);
    chk("R10 byte one cycle", int'(byte_en_o), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule